// File: doc/BRIEF.md
# Pixel pack and expand unit

This block is a 64-bit SIMD pixel-formatting datapath. It takes two 64-bit operands, a 3-bit operation code and a copy of a graphics status word. From these it produces one formatted 64-bit result. The status word supplies the scale factor for the three pack operations.

Three of the operations narrow wide signed lanes. Each lane is scaled left, arithmetically shifted right and then clamped:

- 16-bit lanes become unsigned bytes.
- 32-bit lanes become unsigned bytes. These bytes are merged into a shifted copy of the first operand.
- 32-bit lanes become saturated signed 16-bit fixed-point values.

The other two operations widen data. Expand turns four bytes into four 16-bit lanes that each carry 4 fraction bits. Merge interleaves the bytes of two 32-bit values.

The caller pulses `in_valid` with the operands. Exactly one cycle later the registered result appears with a one-cycle `out_valid` pulse. The result then holds until the next request.

Top module: `pix_fmt_unit`

## Requirements
- R1: After reset, `out_valid`, `illegal` and `result` are all zero.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. Without a request, `result` and `illegal` keep their values.
- R3: Code 0 (16-bit pack) works on each signed 16-bit lane i of `opb`. The lane is shifted left by scale `status[6:3]`, floor-divided by 128 and clamped to 0..255, and the value goes to `result[8i+7:8i]`. `result[63:32]` is zero, and `status[7]` has no effect.
- R4: Code 1 (32-bit pack) works on each signed 32-bit lane j of `opb`. The lane is shifted left by scale `status[7:3]` with no overflow, floor-divided by 2^23 and clamped to 0..255, and the value goes to `result[32j+7:32j]`.
- R5: In code 1, `result[32j+31:32j+8]` equals `opa[32j+23:32j]` for j = 0 and 1.
- R6: Code 2 (fixed-point pack) works on each signed 32-bit lane j of `opb`. The lane is shifted left by scale `status[7:3]`, floor-divided by 65536 and saturated to -32768..32767, and the value goes to `result[16j+15:16j]`. `result[63:32]` is zero.
- R7: Code 3 (expand) places byte i of `opb[31:0]` in `result[16i+11:16i+4]`. All other result bits are zero.
- R8: Code 4 (merge) places byte i of `opb` in `result[16i+7:16i]` and byte i of `opa` in `result[16i+15:16i+8]`, for i = 0..3.
- R9: Codes 5, 6 and 7 give a zero `result` with `illegal` high. Codes 0 to 4 give `illegal` low.
- R10: `status[2:0]` never affects the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; operands are captured this cycle |
| op_sel | input | 3 | Operation code: 0 pack16, 1 pack32, 2 fixed pack, 3 expand, 4 merge |
| opa | input | 64 | First operand (kept bytes for pack32, upper bytes for merge) |
| opb | input | 64 | Second operand (lanes to pack, bytes to expand or merge) |
| status | input | STAT_W | Graphics status word; the scale field starts at bit SCALE_LSB |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 64 | Registered formatted result |
| illegal | output | 1 | High with a result from an unused operation code |

## Verification
The hardest cases to reach are the clamp and saturation boundaries at large scale. There, only a narrow band of lane values lands exactly at 255, at 0, or at the fixed-point limits, and a truncated intermediate would silently wrap a large positive lane into a small or negative one. The bench therefore sweeps every scale value of each pack operation. It pairs each scale with random lanes and with fixed lanes at the signed extremes, at ±1 and at values just across the shift boundary. Expected values come from integer multiply and floor division. Status bits outside the scale field are randomised throughout, so any dependence on them shows up as a mismatch.

// File: rtl/pix_fmt_unit.sv
module pix_fmt_unit #(
  parameter int STAT_W    = 8,
  parameter int SCALE_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [63:0]       opa,
  input  logic [63:0]       opb,
  input  logic [STAT_W-1:0] status,
  output logic              out_valid,
  output logic [63:0]       result,
  output logic              illegal
);
  localparam logic [2:0] OP_PK16 = 3'd0;
  localparam logic [2:0] OP_PK32 = 3'd1;
  localparam logic [2:0] OP_PKFX = 3'd2;
  localparam logic [2:0] OP_EXPD = 3'd3;
  localparam logic [2:0] OP_MRGE = 3'd4;

  logic [3:0]  sc4;
  logic [4:0]  sc5;
  logic [31:0] pk16_w, pkfx_w;
  logic [63:0] pk32_w, expd_w, mrge_w, nxt;
  logic        nxt_ill;

  assign sc4 = status[SCALE_LSB +: 4];
  assign sc5 = status[SCALE_LSB +: 5];

  for (genvar i = 0; i < 4; i++) begin : g_h
    logic signed [31:0] ext, shf;
    assign ext = {{16{opb[16*i+15]}}, opb[16*i +: 16]};
    assign shf = (ext <<< sc4) >>> 7;
    assign pk16_w[8*i +: 8]  = shf[31] ? 8'h00 : (|shf[30:8]) ? 8'hff : shf[7:0];
    assign expd_w[16*i +: 16] = {4'h0, opb[8*i +: 8], 4'h0};
    assign mrge_w[16*i +: 16] = {opa[8*i +: 8], opb[8*i +: 8]};
  end

  for (genvar j = 0; j < 2; j++) begin : g_w
    logic signed [63:0] ext, shf, f23, f16;
    logic [7:0]  byt;
    logic [15:0] fx;
    assign ext = {{32{opb[32*j+31]}}, opb[32*j +: 32]};
    assign shf = ext <<< sc5;
    assign f23 = shf >>> 23;
    assign f16 = shf >>> 16;
    assign byt = f23[63] ? 8'h00 : (|f23[62:8]) ? 8'hff : f23[7:0];
    assign fx  = (f16[63] && !(&f16[62:15])) ? 16'h8000 :
                 (!f16[63] && (|f16[62:15])) ? 16'h7fff : f16[15:0];
    assign pk32_w[32*j +: 32] = {opa[32*j +: 24], byt};
    assign pkfx_w[16*j +: 16] = fx;
  end

  always_comb begin
    nxt     = '0;
    nxt_ill = 1'b0;
    case (op_sel)
      OP_PK16: nxt = {32'h0, pk16_w};
      OP_PK32: nxt = pk32_w;
      OP_PKFX: nxt = {32'h0, pkfx_w};
      OP_EXPD: nxt = expd_w;
      OP_MRGE: nxt = mrge_w;
      default: nxt_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt;
        illegal <= nxt_ill;
      end
    end
  end

  assert_out_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(illegal));
  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> result == 64'h0);
  assert_pack16_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(op_sel) == OP_PK16 |-> result[63:32] == 32'h0 && !illegal);
  assert_pack32_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(op_sel) == OP_PK32 |->
      result[31:8] == $past(opa[23:0]) && result[63:40] == $past(opa[55:32]));
  assert_fix_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(op_sel) == OP_PKFX |-> result[63:32] == 32'h0);
  assert_expand_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(op_sel) == OP_EXPD |-> (result & 64'hF00F_F00F_F00F_F00F) == 64'h0);
  assert_merge_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(op_sel) == OP_MRGE |->
      result[7:0] == $past(opb[7:0]) && result[63:56] == $past(opa[31:24]));
endmodule

// File: tb/pix_fmt_unit_tb.sv
module pix_fmt_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [63:0] opa = '0, opb = '0;
  logic [7:0]  status = '0;
  logic        out_valid, illegal;
  logic [63:0] result;
  int          n_chk = 0, n_bad = 0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_fmt_unit dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa(opa), .opb(opb), .status(status), .out_valid(out_valid), .result(result),
    .illegal(illegal));

  function automatic logic [63:0] nxt_rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  function automatic longint fdiv(longint q, int sh);
    longint d = longint'(1) << sh;
    if (q >= 0) return q / d;
    return -((-q + d - 1) / d);
  endfunction

  function automatic logic [63:0] exp_pk16(logic [63:0] b, logic [7:0] st);
    logic [63:0] r = '0;
    int s = int'(st[6:3]);
    for (int i = 0; i < 4; i++) begin
      longint v = longint'(shortint'(b[16*i +: 16]));
      longint f = fdiv(v * (longint'(1) << s), 7);
      longint c = (f < 0) ? 0 : (f > 255) ? 255 : f;
      r[8*i +: 8] = c[7:0];
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_pk32(logic [63:0] a, logic [63:0] b, logic [7:0] st);
    logic [63:0] r = '0;
    int s = int'(st[7:3]);
    for (int j = 0; j < 2; j++) begin
      longint v = longint'(int'(b[32*j +: 32]));
      longint f = fdiv(v * (longint'(1) << s), 23);
      longint c = (f < 0) ? 0 : (f > 255) ? 255 : f;
      r[32*j+8 +: 24] = a[32*j +: 24];
      r[32*j +: 8] = c[7:0];
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_pkfx(logic [63:0] b, logic [7:0] st);
    logic [63:0] r = '0;
    int s = int'(st[7:3]);
    for (int j = 0; j < 2; j++) begin
      longint v = longint'(int'(b[32*j +: 32]));
      longint f = fdiv(v * (longint'(1) << s), 16);
      longint c = (f < -32768) ? -32768 : (f > 32767) ? 32767 : f;
      r[16*j +: 16] = c[15:0];
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_expd(logic [63:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(b[8*i +: 8]) * 16'd16;
    return r;
  endfunction

  function automatic logic [63:0] exp_mrge(logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      r[16*i +: 8]   = b[8*i +: 8];
      r[16*i+8 +: 8] = a[8*i +: 8];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, expv);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic [7:0] st,
                       logic [63:0] er, logic eill, string tag);
    op_sel = op; opa = a; opb = b; status = st; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    opa = nxt_rnd(); opb = nxt_rnd(); op_sel = 3'(nxt_rnd()); status = 8'(nxt_rnd());
    chk("R2 out_valid pulse", 64'(out_valid), 64'd1);
    chk(tag, result, er);
    chk({tag, " illegal (R9)"}, 64'(illegal), 64'(eill));
    @(negedge clk);
    chk("R2 out_valid drop", 64'(out_valid), 64'd0);
    chk("R2 result hold", result, er);
  endtask

  function automatic logic [63:0] special(int k);
    case (k)
      0: return 64'h7FFF_8000_0001_FFFF;
      1: return 64'h0080_007F_0100_00FF;
      2: return 64'h7FFF_FFFF_8000_0000;
      3: return 64'h0080_0000_FF80_0000;
      4: return 64'h0000_0001_FFFF_FFFF;
      default: return 64'h0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", 64'(out_valid), 64'd0);
    chk("R1 reset result", result, 64'd0);
    chk("R1 reset illegal", 64'(illegal), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 14; k++) begin
        logic [63:0] b = (k < 6) ? special(k) : nxt_rnd();
        logic [63:0] a = nxt_rnd();
        logic [7:0] st = {1'(nxt_rnd()), 4'(s), 3'(nxt_rnd())};
        issue(3'd0, a, b, st, exp_pk16(b, st), 1'b0, "R3 R10 pack16");
      end

    for (int s = 0; s < 32; s++)
      for (int k = 0; k < 12; k++) begin
        logic [63:0] b = (k < 6) ? special(k) : nxt_rnd();
        logic [63:0] a = nxt_rnd();
        logic [7:0] st = {5'(s), 3'(nxt_rnd())};
        if (k > 8) b = {32'(int'(b[63:32]) >>> (s + 2)), 32'(int'(b[31:0]) >>> (s + 1))};
        issue(3'd1, a, b, st, exp_pk32(a, b, st), 1'b0, "R4 R5 R10 pack32");
        issue(3'd2, a, b, st, exp_pkfx(b, st), 1'b0, "R6 R10 fixed pack");
      end

    for (int x = 0; x < 256; x++) begin
      logic [7:0] v = 8'(x);
      logic [63:0] b = {nxt_rnd()[63:32], v, ~v, v ^ 8'h5a, v + 8'd1};
      issue(3'd3, nxt_rnd(), b, 8'(nxt_rnd()), exp_expd(b), 1'b0, "R7 expand");
    end

    for (int k = 0; k < 40; k++) begin
      logic [63:0] a = nxt_rnd();
      logic [63:0] b = nxt_rnd();
      issue(3'd4, a, b, 8'(nxt_rnd()), exp_mrge(a, b), 1'b0, "R8 merge");
    end

    for (int c = 5; c < 8; c++)
      for (int k = 0; k < 3; k++)
        issue(3'(c), nxt_rnd(), nxt_rnd(), 8'(nxt_rnd()), 64'h0, 1'b1, "R9 illegal code");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule